// File: doc/BRIEF.md
# Immediate-Controlled Lane Element Shuffler

This block reorders the elements of one source vector, up to 256 bits wide, under the control of an 8-bit immediate. Four 2-bit selectors are packed in the immediate. Each selector picks which source element lands in one destination slot. Selection never leaves a 128-bit lane, and every lane uses the same immediate. A mode input picks the element size and which part of each lane is permuted. A size input sets how many result bytes are live. Every byte above that size is cleared.

Operands arrive on a valid/ready input stream, and results leave on a valid/ready output stream. A single output register separates the two streams. An accepted operand shows up at the output on the next clock edge. While the output holds a result that has not been taken (`out_valid` high, `out_ready` low), the register holds its value and `in_ready` stays low. The input side may therefore only count a beat as delivered on a cycle where `in_valid` and `in_ready` are both high. The output side sees a result as delivered when `out_valid` and `out_ready` are both high. When the output register is empty or being drained in the same cycle, `in_ready` is high. Nothing else stalls the block.

Top module: `shuf_unit`

## Requirements
- R1: In doubleword mode (`in_mode` = 3), destination 32-bit element j (j = 0..3) of each 128-bit lane is source element number `in_imm[2j+1:2j]` of the same lane.
- R2: For vectors wider than 128 bits, each 128-bit lane is permuted on its own with the same immediate, and no element crosses a lane boundary.
- R3: In low-word mode (`in_mode` = 1), words 0..3 of each lane take lane word `in_imm[2j+1:2j]` for slot j, and lane bits 127:64 are copied unchanged.
- R4: In high-word mode (`in_mode` = 2), lane word 4+j takes lane word 4 + `in_imm[2j+1:2j]`, and lane bits 63:0 are copied unchanged.
- R5: In narrow word mode (`in_mode` = 0), the four 16-bit words of every 64-bit group are permuted with the four selectors, and each word stays within its own group.
- R6: With a legal size of S bytes, every result byte at index S or above is zero.
- R7: Any `in_size` other than 8, 16 or 32 (or larger than the vector) gives an all-zero result.
- R8: A beat accepted at a clock edge appears on `out_data` with `out_valid` high after that edge. With `out_ready` high and no beat accepted, `out_valid` is low after the edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_data` keep their values through the next edge.
- R10: After reset, `out_valid` is low, `out_data` is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_data | input | VEC_W (256) | Source vector |
| in_imm | input | 8 | Four packed 2-bit selectors, slot j in bits 2j+1:2j |
| in_mode | input | 2 | 0 narrow word, 1 low words, 2 high words, 3 doublewords |
| in_size | input | SIZE_W (6) | Live result bytes: 8, 16 or 32 |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | VEC_W (256) | Permuted and size-masked result |

## Verification
The bench sweeps every immediate in every mode at each legal size. It uses source patterns in which every word and doubleword is distinct. A selector read from the wrong immediate bits, or a swapped mode encoding, therefore gives a visibly different result. A design that moves elements across the 128-bit boundary, or that fails to pass the untouched half through in the low-word and high-word modes, corrupts the upper lane or the copied half. Off-by-one size masking leaves stale bytes just above the size, and a loose legality check lets illegal sizes such as 24 or 63 produce data instead of zeros. A stall test offers a second beat while the output is held. An output register that overwrites its value or reports ready during the stall drops or duplicates a result.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int LANE_W = 128;
  localparam int WORD_W = 16;
  localparam int DW_W   = 32;
  localparam int NSEL   = 4;

  typedef enum logic [1:0] {
    SHUF_W64  = 2'd0,
    SHUF_LOW  = 2'd1,
    SHUF_HIGH = 2'd2,
    SHUF_DW   = 2'd3
  } shuf_mode_e;

  function automatic logic [1:0] pick(input logic [7:0] imm, input int slot);
    return imm[2*slot +: 2];
  endfunction
endpackage

// File: rtl/shuf_lane.sv
module shuf_lane
  import shuf_pkg::*;
(
  input  logic [LANE_W-1:0] lane_in,
  input  logic [7:0]        imm,
  input  shuf_mode_e        mode,
  output logic [LANE_W-1:0] lane_out
);
  localparam int NWORD = LANE_W / WORD_W;
  localparam int NDW   = LANE_W / DW_W;
  localparam int HALF  = NWORD / 2;

  logic [WORD_W-1:0] wsrc [NWORD];
  logic [DW_W-1:0]   dsrc [NDW];
  logic [WORD_W-1:0] lo_perm [NSEL];
  logic [WORD_W-1:0] hi_perm [NSEL];
  logic [DW_W-1:0]   dw_perm [NSEL];

  for (genvar w = 0; w < NWORD; w++) begin : g_wsplit
    assign wsrc[w] = lane_in[w*WORD_W +: WORD_W];
  end
  for (genvar d = 0; d < NDW; d++) begin : g_dsplit
    assign dsrc[d] = lane_in[d*DW_W +: DW_W];
  end

  for (genvar j = 0; j < NSEL; j++) begin : g_sel
    assign lo_perm[j] = wsrc[pick(imm, j)];
    assign hi_perm[j] = wsrc[HALF + int'(pick(imm, j))];
    assign dw_perm[j] = dsrc[pick(imm, j)];
  end

  logic [LANE_W/2-1:0] lo_half, hi_half, dw_lo, dw_hi;
  always_comb begin
    for (int j = 0; j < NSEL; j++) begin
      lo_half[j*WORD_W +: WORD_W] = lo_perm[j];
      hi_half[j*WORD_W +: WORD_W] = hi_perm[j];
    end
    dw_lo = {dw_perm[1], dw_perm[0]};
    dw_hi = {dw_perm[3], dw_perm[2]};
  end

  always_comb begin
    unique case (mode)
      SHUF_W64:  lane_out = {hi_half, lo_half};
      SHUF_LOW:  lane_out = {lane_in[LANE_W-1:LANE_W/2], lo_half};
      SHUF_HIGH: lane_out = {hi_half, lane_in[LANE_W/2-1:0]};
      default:   lane_out = {dw_hi, dw_lo};
    endcase
  end
endmodule

// File: rtl/shuf_size_mask.sv
module shuf_size_mask #(
  parameter int NBYTES = 32,
  parameter int SIZE_W = 6
) (
  input  logic [SIZE_W-1:0] size,
  output logic [NBYTES-1:0] live
);
  logic legal;
  always_comb begin
    legal = ((int'(size) == 8) || (int'(size) == 16) || (int'(size) == 32))
            && (int'(size) <= NBYTES);
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign live[b] = legal && (b < int'(size));
  end
endmodule

// File: rtl/shuf_unit.sv
module shuf_unit
  import shuf_pkg::*;
#(
  parameter int VEC_W = 256,
  localparam int SIZE_W = $clog2(VEC_W/8) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  in_data,
  input  logic [7:0]        in_imm,
  input  logic [1:0]        in_mode,
  input  logic [SIZE_W-1:0] in_size,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_data
);
  localparam int NLANES = VEC_W / LANE_W;
  localparam int NBYTES = VEC_W / 8;

  logic [VEC_W-1:0]  permuted;
  logic [VEC_W-1:0]  masked;
  logic [NBYTES-1:0] live;
  shuf_mode_e        mode_e;

  assign mode_e = shuf_mode_e'(in_mode);

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    shuf_lane u_lane (
      .lane_in  (in_data[l*LANE_W +: LANE_W]),
      .imm      (in_imm),
      .mode     (mode_e),
      .lane_out (permuted[l*LANE_W +: LANE_W])
    );
  end

  shuf_size_mask #(.NBYTES(NBYTES), .SIZE_W(SIZE_W)) u_mask (
    .size (in_size),
    .live (live)
  );

  for (genvar b = 0; b < NBYTES; b++) begin : g_apply
    assign masked[b*8 +: 8] = live[b] ? permuted[b*8 +: 8] : 8'h00;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= masked;
    end
  end
endmodule

// File: rtl/shuf_unit_chk.sv
module shuf_unit_chk #(
  parameter int VEC_W = 256,
  parameter int SIZE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [VEC_W-1:0]  in_data,
  input logic [1:0]        in_mode,
  input logic [SIZE_W-1:0] in_size,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VEC_W-1:0]  out_data
);
  // R8
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  idle_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  narrow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && int'(in_size) == 8) |=> (out_data[VEC_W-1:64] == '0));

  // R7
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && int'(in_size) != 8 && int'(in_size) != 16
     && int'(in_size) != 32) |=> (out_data == '0));

  // R3
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 2'd1 && int'(in_size) == 16)
    |=> (out_data[127:64] == $past(in_data[127:64])));

  // R4
  high_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 2'd2 && int'(in_size) == 16)
    |=> (out_data[63:0] == $past(in_data[63:0])));
endmodule

bind shuf_unit shuf_unit_chk #(.VEC_W(VEC_W), .SIZE_W(SIZE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_mode   (in_mode),
  .in_size   (in_size),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/shuf_unit_test.sv
module shuf_unit_test;
  localparam int VW = 256;
  localparam int NW = VW / 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_data = '0;
  logic [7:0]    in_imm = '0;
  logic [1:0]    in_mode = '0;
  logic [5:0]    in_size = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  shuf_unit #(.VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_imm(in_imm), .in_mode(in_mode), .in_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      finish_run();
    end
  end

  function automatic logic [VW-1:0] model(input logic [VW-1:0] d, input logic [7:0] imm,
                                          input int mode, input int size);
    logic [VW-1:0] r;
    r = '0;
    if (!(size == 8 || size == 16 || size == 32)) return r;
    for (int w = 0; w < NW; w++) begin
      int src, lane, pos, j;
      lane = w / 8;
      pos  = w % 8;
      src  = w;
      if (mode == 0) begin
        j = w % 4;
        src = (w / 4) * 4 + int'(imm[2*j +: 2]);
      end else if (mode == 1) begin
        if (pos < 4) src = lane * 8 + int'(imm[2*pos +: 2]);
      end else if (mode == 2) begin
        if (pos >= 4) src = lane * 8 + 4 + int'(imm[2*(pos-4) +: 2]);
      end else begin
        j = (w / 2) % 4;
        src = 2 * ((w / 8) * 4 + int'(imm[2*j +: 2])) + (w % 2);
      end
      if (2 * w < size) r[w*16 +: 16] = d[src*16 +: 16];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] pattern(input int p);
    logic [VW-1:0] v;
    for (int w = 0; w < NW; w++)
      v[w*16 +: 16] = (p == 0) ? 16'h1000 + 16'(w) * 16'h0101
                               : 16'hF0E0 ^ (16'(w) * 16'h1111);
    return v;
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one beat (caller is just after a negedge), check it one edge later.
  task automatic beat(input string tag, input logic [VW-1:0] d, input logic [7:0] imm,
                      input int mode, input int size);
    in_valid = 1'b1;
    in_data  = d;
    in_imm   = imm;
    in_mode  = 2'(mode);
    in_size  = 6'(size);
    @(negedge clk);
    chk_bit({tag, " valid"}, out_valid, 1'b1);
    chk_vec(tag, out_data, model(d, imm, mode, size));
  endtask

  initial begin
    string tags [4];
    tags[0] = "R5";
    tags[1] = "R3";
    tags[2] = "R4";
    tags[3] = "R1";

    #5;
    // R10 reset state
    chk_bit("R10 out_valid", out_valid, 1'b0);
    chk_vec("R10 out_data", out_data, '0);
    chk_bit("R10 in_ready", in_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Full sweep: every immediate, every mode, every legal size
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 3; s++)
          for (int i = 0; i < 256; i++) begin
            string t;
            int sz;
            sz = 8 << s;
            t = tags[m];
            if (p == 1 && sz == 32) t = {"R2 ", tags[m]};
            if (p == 1 && sz < 32) t = {"R6 ", tags[m]};
            beat(t, pattern(p), 8'(i), m, sz);
          end

    // R7 illegal sizes
    for (int m = 0; m < 4; m++) begin
      beat("R7 size0", pattern(0), 8'hA5, m, 0);
      beat("R7 size4", pattern(0), 8'h1B, m, 4);
      beat("R7 size24", pattern(1), 8'hE4, m, 24);
      beat("R7 size33", pattern(1), 8'h4E, m, 33);
      beat("R7 size63", pattern(0), 8'hFF, m, 63);
    end

    // R8 idle drain
    in_valid = 1'b0;
    @(negedge clk);
    chk_bit("R8 idle out_valid", out_valid, 1'b0);

    // R9 back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = pattern(0);
    in_imm = 8'h1B;
    in_mode = 2'd3;
    in_size = 6'd32;
    @(negedge clk);
    chk_bit("R8 stall accept", out_valid, 1'b1);
    chk_vec("R8 stall first", out_data, model(pattern(0), 8'h1B, 3, 32));
    in_data = pattern(1);
    in_imm = 8'hE4;
    in_mode = 2'd0;
    chk_bit("R9 in_ready low", in_ready, 1'b0);
    @(negedge clk);
    chk_bit("R9 hold valid", out_valid, 1'b1);
    chk_vec("R9 hold data", out_data, model(pattern(0), 8'h1B, 3, 32));
    chk_bit("R9 still blocked", in_ready, 1'b0);
    out_ready = 1'b1;
    @(negedge clk);
    chk_vec("R9 second beat", out_data, model(pattern(1), 8'hE4, 0, 32));
    in_valid = 1'b0;
    @(negedge clk);
    chk_bit("R8 drained", out_valid, 1'b0);
    chk_bit("R10 ready again", in_ready, 1'b1);

    finish_run();
  end
endmodule